// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

This unit inspects one 32-bit binary32 operand per cycle and reports which of six classes it falls into: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. When the operand is a signaling NaN, the unit also produces the matching quiet NaN and records an invalid-operation event in a sticky flag. Any other operand is passed through unchanged.

A mode input picks how the top fraction bit is read. With `quiet_hi` high, a set top fraction bit marks a quiet NaN, as in the 2008 revision of the standard. With `quiet_hi` low, the meaning is reversed, as in the legacy convention. In legacy mode the quieting step clears that bit, so it has to make sure the result does not turn into an infinity. The class, result and valid outputs sit behind one optional register stage, selected by a parameter. The sticky flag is always a register.

Top module: `fp32_nan_guard`

## Requirements
- R1: `cls_out` is one-hot over six bits, with bit 0 zero, bit 1 subnormal, bit 2 normal, bit 3 infinity, bit 4 quiet NaN and bit 5 signaling NaN. It describes the input operand, not the quieted result.
- R2: An operand whose exponent field (bits 30:23) is all ones is an infinity when its fraction (bits 22:0) is zero, and a NaN otherwise.
- R3: An operand with an all-zero exponent is zero when its fraction is zero and subnormal otherwise. Every other exponent value is normal. The sign (bit 31) does not affect the class.
- R4: A NaN is signaling when fraction bit 22 differs from `quiet_hi`: bit 22 = 0 with `quiet_hi` = 1, or bit 22 = 1 with `quiet_hi` = 0.
- R5: With `quiet_hi` = 1, a signaling NaN is quieted by setting bit 22. The sign, the exponent and bits 21:0 are unchanged.
- R6: With `quiet_hi` = 0, a signaling NaN is quieted by clearing bit 22. If bits 21:0 are then all zero, bit 21 is set so that the result remains a NaN. All other bits are unchanged.
- R7: An operand that is not a signaling NaN appears on `res_out` bit for bit.
- R8: `invalid_flag` becomes 1 on the clock edge that accepts a valid signaling NaN and stays 1 until it is cleared.
- R9: `flag_clr` clears `invalid_flag` on the next edge. If a valid signaling NaN arrives in the same cycle, setting takes priority and the flag stays 1.
- R10: With the default `REG_OUT` = 1, `res_out`, `cls_out` and `res_valid` reflect the inputs one clock after they are applied. Reset drives all outputs to zero.
- R11: A signaling NaN presented while `op_valid` is low does not change `invalid_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operand is valid this cycle |
| op_in | input | 32 | Binary32 operand |
| quiet_hi | input | 1 | 1: a set top fraction bit means quiet; 0: legacy meaning |
| flag_clr | input | 1 | Synchronous clear of the sticky invalid flag |
| res_valid | output | 1 | Result outputs are valid |
| res_out | output | 32 | Quieted operand, or the operand unchanged |
| cls_out | output | 6 | One-hot class of the operand |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The combinational checks assume that `op_in` and `quiet_hi` carry known values from time zero. They also assume the mode is read in the same cycle as the operand, so the quieting rule and the signaling test always refer to the same mode. The clocked checks on the flag assume that `op_valid` and `flag_clr` never float. The stimulus drives every input to a defined value before the first edge and changes inputs only on falling edges. It holds the operand at zero throughout reset, and it switches the mode freely between vectors but never within one.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int CLS_N    = 6;
  localparam int CLS_ZERO = 0;
  localparam int CLS_SUB  = 1;
  localparam int CLS_NORM = 2;
  localparam int CLS_INF  = 3;
  localparam int CLS_QNAN = 4;
  localparam int CLS_SNAN = 5;
  typedef logic [CLS_N-1:0] cls_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
  import fpc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  input  logic                  quiet_hi,
  output cls_t                  cls,
  output logic                  is_snan
);
  logic exp_ones, exp_zero, frac_nz, top_bit;

  always_comb begin
    exp_ones = &op[FRAC_W +: EXP_W];
    exp_zero = ~|op[FRAC_W +: EXP_W];
    frac_nz  = |op[FRAC_W-1:0];
    top_bit  = op[FRAC_W-1];
    cls      = '0;
    if (exp_ones) begin
      if (!frac_nz)                cls[CLS_INF]  = 1'b1;
      else if (top_bit ^ quiet_hi) cls[CLS_SNAN] = 1'b1;
      else                         cls[CLS_QNAN] = 1'b1;
    end else if (exp_zero) begin
      if (frac_nz) cls[CLS_SUB]  = 1'b1;
      else         cls[CLS_ZERO] = 1'b1;
    end else begin
      cls[CLS_NORM] = 1'b1;
    end
    is_snan = cls[CLS_SNAN];
  end

  // One class per operand (R1)
  always_comb begin
    assert_cls_onehot_R1: assert ($countones(cls) == 1);
  end
endmodule

// File: rtl/fpc_quiet.sv
module fpc_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  input  logic                  is_snan,
  input  logic                  quiet_hi,
  output logic [EXP_W+FRAC_W:0] res
);
  localparam int TOP = FRAC_W - 1;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    frac = op[FRAC_W-1:0];
    if (is_snan) begin
      if (quiet_hi) begin
        frac[TOP] = 1'b1;
      end else begin
        frac[TOP] = 1'b0;
        if (frac == '0) frac[TOP-1] = 1'b1;
      end
    end
    res = {op[EXP_W+FRAC_W:FRAC_W], frac};
  end

  always_comb begin
    if (!is_snan) begin
      assert_passthru_R7: assert (res == op);
    end else begin
      assert_nan_kept_R6: assert ((&res[FRAC_W +: EXP_W]) && (|res[FRAC_W-1:0]));
      if (quiet_hi) begin
        assert_qbit_set_R5: assert (res[TOP] && res[TOP-1:0] == op[TOP-1:0]);
      end
    end
  end
endmodule

// File: rtl/fpc_sticky.sv
module fpc_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/fp32_nan_guard.sv
module fp32_nan_guard
  import fpc_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  input  logic [EXP_W+FRAC_W:0] op_in,
  input  logic                  quiet_hi,
  input  logic                  flag_clr,
  output logic                  res_valid,
  output logic [EXP_W+FRAC_W:0] res_out,
  output logic [CLS_N-1:0]      cls_out,
  output logic                  invalid_flag
);
  localparam int W = EXP_W + FRAC_W + 1;

  cls_t          cls_c;
  logic          snan_c;
  logic [W-1:0]  res_c;

  fpc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .op(op_in), .quiet_hi(quiet_hi), .cls(cls_c), .is_snan(snan_c)
  );

  fpc_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
    .op(op_in), .is_snan(snan_c), .quiet_hi(quiet_hi), .res(res_c)
  );

  fpc_sticky u_flag (
    .clk(clk), .rst(rst), .set(op_valid & snan_c), .clr(flag_clr),
    .flag(invalid_flag)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          res_valid <= 1'b0;
          res_out   <= '0;
          cls_out   <= '0;
        end else begin
          res_valid <= op_valid;
          res_out   <= res_c;
          cls_out   <= cls_c;
        end
      end

      assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);
      assert_out_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $countones(cls_out) == 1);
      assert_idle_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !flag_clr) |=> $stable(invalid_flag));
    end else begin : g_comb
      always_comb begin
        res_valid = op_valid;
        res_out   = res_c;
        cls_out   = cls_c;
      end
    end
  endgenerate
endmodule

// File: tb/sim_fp32_nan_guard.sv
module sim_fp32_nan_guard;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [31:0] op_in = '0;
  logic        quiet_hi = 1'b1;
  logic        flag_clr = 1'b0;
  logic        res_valid;
  logic [31:0] res_out;
  logic [5:0]  cls_out;
  logic        invalid_flag;

  int nchk = 0;
  int nfail = 0;
  logic mflag = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  fp32_nan_guard u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_in(op_in),
    .quiet_hi(quiet_hi), .flag_clr(flag_clr), .res_valid(res_valid),
    .res_out(res_out), .cls_out(cls_out), .invalid_flag(invalid_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // class index: 0 zero, 1 sub, 2 norm, 3 inf, 4 qnan, 5 snan
  function automatic int ref_class(input logic [31:0] v, input logic qh);
    int e = int'(v[30:23]);
    int f = int'(v[22:0]);
    if (e == 255) begin
      if (f == 0) return 3;
      if ((f >= 32'h40_0000) != (qh == 1'b1)) return 5;
      return 4;
    end
    if (e == 0) return (f == 0) ? 0 : 1;
    return 2;
  endfunction

  function automatic logic [31:0] ref_result(input logic [31:0] v, input logic qh);
    logic [31:0] r = v;
    if (ref_class(v, qh) != 5) return r;
    if (qh) r = r | 32'h0040_0000;
    else begin
      r = r & ~32'h0040_0000;
      if (r[22:0] == 0) r = r | 32'h0020_0000;
    end
    return r;
  endfunction

  task automatic step(input logic v, input logic [31:0] op, input logic qh, input logic clr);
    int c;
    logic [31:0] er;
    logic set;
    @(negedge clk);
    op_valid = v; op_in = op; quiet_hi = qh; flag_clr = clr;
    c   = ref_class(op, qh);
    er  = ref_result(op, qh);
    set = v && (c == 5);
    mflag = set ? 1'b1 : (clr ? 1'b0 : mflag);
    @(negedge clk);
    chk("R10 res_valid", {31'd0, res_valid}, {31'd0, v});
    chk("R1 one-hot count", $countones(cls_out), 1);
    chk(c >= 4 ? "R4 class" : (c == 3 ? "R2 class" : "R3 class"),
        {26'd0, cls_out}, 32'd1 << c);
    chk(c == 5 ? (qh ? "R5 result" : "R6 result") : "R7 result", res_out, er);
    chk(clr ? "R9 flag" : (!v && c == 5 ? "R11 flag" : "R8 flag"),
        {31'd0, invalid_flag}, {31'd0, mflag});
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {31'd0, res_valid}, 0);
    chk("R10 reset res", res_out, 0);
    chk("R10 reset cls", {26'd0, cls_out}, 0);
    chk("R10 reset flag", {31'd0, invalid_flag}, 0);
    rst = 1'b0;

    step(1, 32'h0000_0000, 1, 0);   // +0
    step(1, 32'h8000_0000, 0, 0);   // -0
    step(1, 32'h0000_0001, 1, 0);   // subnormal
    step(1, 32'h3F80_0000, 1, 0);   // 1.0
    step(1, 32'hFF80_0000, 0, 0);   // -inf
    step(1, 32'h7FC0_0000, 1, 0);   // quiet in 2008 mode
    step(1, 32'h7F80_0001, 0, 0);   // quiet in legacy mode
    step(0, 32'h7F80_0001, 1, 0);   // signaling but not valid: R11
    step(1, 32'h7F80_0001, 1, 0);   // signaling 2008 -> 7FC00001, flag set
    step(1, 32'h3F80_0000, 1, 0);   // flag holds
    step(1, 32'h3F80_0000, 1, 1);   // clear
    step(1, 32'h7FC0_0000, 0, 0);   // legacy snan, fraction empties -> 7FA00000
    step(1, 32'h0000_0000, 1, 1);   // clear
    step(1, 32'hFFC0_0005, 0, 1);   // clear and set together: set wins
    step(1, 32'hFFBF_FFFF, 1, 0);   // 2008 snan full payload
    step(0, 32'h0000_0000, 1, 1);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] v;
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      v = seed;
      if (i % 3 == 0) v[30:23] = 8'hFF;
      if (i % 7 == 0) v[30:23] = 8'h00;
      if (i % 11 == 0) v[21:0] = '0;
      step(seed[24] | seed[3], v, seed[9], seed[15] & seed[16]);
    end

    report();
    $finish;
  end
endmodule